// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block watches a running calendar and raises an interrupt when the time reaches a programmed alarm. It has two independent alarm units. Each unit stores six compare fields: second, minute, hour, date, month and weekday. Every field carries its own enable flag, so software can match on any subset of fields. For example, it can match "every hour at minute 30" or "every Monday at 07:00:00".

The time arrives as BCD fields from an external timekeeper, together with a one-cycle pulse that marks each new second. The comparison is made only on that pulse, once the new time is already on the inputs. A hit sets a sticky status flag for that alarm. A control register chooses between two interrupt behaviours:
- **Single-event mode:** the interrupt follows the latched flags until software reads the status register.
- **Repeat mode:** the interrupt is a periodic source that stays high for exactly one tick period after each hit.

A per-alarm gate decides which alarms reach the interrupt pin. Software reaches the alarm fields, the control register and the status register through a simple synchronous read/write port.

Top module: `cal_alarm_match`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `irq` is 0. Reset clears every alarm field, the control register and both status flags, so reads of them return 0.
- R2: Register map and bus timing:
  - Alarm unit a, field f lives at address 8*a+f. The field order is second=0, minute=1, hour=2, date=3, month=4, weekday=5.
  - Control is at address 16: bit0 selects repeat mode, bit1 gates alarm 0 onto `irq`, bit2 gates alarm 1.
  - Status is at address 17: bit0 is the alarm 0 flag, bit1 is the alarm 1 flag.
  - A read returns its data on `rdata` in the cycle after `rd_en`. `rdata` is 0 after a cycle with no read, and unmapped addresses read 0.
  - Alarm fields read back all 8 bits that were written. Control reads back its 3 bits and 0 above them.
- R3: In an alarm field, bit7 is the compare enable and bits 6:0 hold the BCD value. An alarm hits when every enabled field equals the matching time input.
- R4: A field with bit7 clear has no effect on whether its alarm hits, whatever the value of that time field.
- R5: An alarm is evaluated only in a cycle with `tick` high. Its status flag is visible from the next cycle. Without `tick`, no flag is set, even if the time matches.
- R6: An alarm with no enabled field never sets its flag.
- R7: A read of the status register clears both flags at the end of that read cycle. If an alarm hits in the same cycle as the read, its flag stays set. The read returns the flags as they stood before the read.
- R8: In single-event mode, `irq` is high in every cycle where a gated alarm's flag is set. It stays high until a status read clears the flag.
- R9: In repeat mode, `irq` rises in the cycle after a hitting tick and stays high until the next tick without a hit. The status flags still latch as in R5.
- R10: When both alarms hit on the same tick, both flags are set, and `irq` is the OR of the gated alarms.
- R11: An alarm whose gate bit is 0 still sets its flag but never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per second; the time inputs already hold the new value |
| cur_sec | input | 7 | Current seconds, BCD 00-59 |
| cur_min | input | 7 | Current minutes, BCD 00-59 |
| cur_hour | input | 6 | Current hour, BCD 00-23 |
| cur_date | input | 6 | Current day of month, BCD 01-31 |
| cur_month | input | 5 | Current month, BCD 01-12 |
| cur_wday | input | 3 | Current weekday, 0-6 |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt, active high, registered |

## Verification
A corrupted alarm field or enable bit shows up at the first tick where the time and the alarm disagree: `irq` and the status flag either rise when they should not or fail to rise, and both become visible one cycle after that tick. A stuck or lost status flag shows on the next status read and, in single-event mode, on `irq` in the very next cycle. A wrong repeat-pulse state appears as `irq` staying high past the following non-hitting tick. The reference model is compared against `irq` and `rdata` on every cycle, so such a divergence is reported within one clock of reaching a pin.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  // number of compare fields per alarm unit
  localparam int NUM_FIELDS = 6;
  // address bits that select a field inside one unit
  localparam int FIELD_AW   = 3;
  // widest BCD time field
  localparam int VAL_W      = 7;

  typedef enum logic [FIELD_AW-1:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_WDAY  = 3'd5
  } field_e;

  // number of meaningful BCD bits for each field
  function automatic int field_bits(input int f);
    case (f)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [FIELD_AW-1:0]              wr_field,
  input  logic [DATA_W-1:0]                wdata,
  input  logic [FIELD_AW-1:0]              rd_field,
  output logic [DATA_W-1:0]                rd_val,
  input  logic [NUM_FIELDS-1:0][VAL_W-1:0] cur_time,
  output logic                             match
);
  localparam int EN_BIT = DATA_W - 1;
  localparam logic [FIELD_AW-1:0] LAST_FLD = FIELD_AW'(NUM_FIELDS - 1);

  logic [DATA_W-1:0]     cfg_q [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] fld_en;
  logic [NUM_FIELDS-1:0] fld_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_FIELDS; i++) cfg_q[i] <= '0;
    end else if (wr_en && (wr_field <= LAST_FLD)) begin
      cfg_q[wr_field] <= wdata;
    end
  end

  // one masked comparator per field, sized to that field's BCD width
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
    localparam int FW = field_bits(f);
    assign fld_en[f]  = cfg_q[f][EN_BIT];
    assign fld_hit[f] = !fld_en[f] || (cfg_q[f][FW-1:0] == cur_time[f][FW-1:0]);
  end

  assign match  = (|fld_en) && (&fld_hit);
  assign rd_val = (rd_field <= LAST_FLD) ? cfg_q[rd_field] : '0;
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq #(
  parameter int N_ALARMS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [N_ALARMS-1:0] match,
  input  logic                clr,
  input  logic                rep_mode,
  input  logic [N_ALARMS-1:0] irq_en,
  output logic [N_ALARMS-1:0] flags,
  output logic                irq
);
  logic [N_ALARMS-1:0] flag_q, flag_n;
  logic [N_ALARMS-1:0] pulse_q, pulse_n;
  logic [N_ALARMS-1:0] src;
  logic                irq_q;

  always_comb begin
    // a hit in the clearing cycle survives the clear
    flag_n  = (tick ? match : '0) | (clr ? '0 : flag_q);
    // the pulse state is refreshed on every tick
    pulse_n = tick ? match : pulse_q;
    src     = rep_mode ? pulse_n : flag_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q  <= '0;
      pulse_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      pulse_q <= pulse_n;
      irq_q   <= |(src & irq_en);
    end
  end

  assign flags = flag_q;
  assign irq   = irq_q;
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter  int N_ALARMS = 2,
  parameter  int DATA_W   = 8,
  localparam int UNIT_AW  = (N_ALARMS > 1) ? $clog2(N_ALARMS) : 1,
  localparam int ADDR_W   = FIELD_AW + UNIT_AW + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [6:0]        cur_sec,
  input  logic [6:0]        cur_min,
  input  logic [5:0]        cur_hour,
  input  logic [5:0]        cur_date,
  input  logic [4:0]        cur_month,
  input  logic [2:0]        cur_wday,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = {1'b1, {(ADDR_W-1){1'b0}}};
  localparam logic [ADDR_W-1:0] STAT_ADDR = {1'b1, {(ADDR_W-2){1'b0}}, 1'b1};

  logic [NUM_FIELDS-1:0][VAL_W-1:0] cur_time;
  logic [N_ALARMS-1:0]              match_vec;
  logic [N_ALARMS-1:0]              flags;
  logic [DATA_W-1:0]                rd_vals [N_ALARMS];
  logic                             im_q;
  logic [N_ALARMS-1:0]              al_en_q;
  logic [DATA_W-1:0]                rdata_q, rd_next;
  logic                             sel_alarm;
  logic [UNIT_AW-1:0]               unit_sel;
  logic [FIELD_AW-1:0]              field_sel;
  logic                             stat_rd;

  assign cur_time[FLD_SEC]   = cur_sec;
  assign cur_time[FLD_MIN]   = cur_min;
  assign cur_time[FLD_HOUR]  = {1'b0, cur_hour};
  assign cur_time[FLD_DATE]  = {1'b0, cur_date};
  assign cur_time[FLD_MONTH] = {2'b00, cur_month};
  assign cur_time[FLD_WDAY]  = {4'b0000, cur_wday};

  assign sel_alarm = !addr[ADDR_W-1];
  assign unit_sel  = addr[ADDR_W-2 -: UNIT_AW];
  assign field_sel = addr[FIELD_AW-1:0];
  assign stat_rd   = rd_en && (addr == STAT_ADDR);

  for (genvar u = 0; u < N_ALARMS; u++) begin : g_unit
    cal_alarm_unit #(.DATA_W(DATA_W)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en && sel_alarm && (unit_sel == UNIT_AW'(u))),
      .wr_field (field_sel),
      .wdata    (wdata),
      .rd_field (field_sel),
      .rd_val   (rd_vals[u]),
      .cur_time (cur_time),
      .match    (match_vec[u])
    );
  end

  cal_alarm_irq #(.N_ALARMS(N_ALARMS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .match    (match_vec),
    .clr      (stat_rd),
    .rep_mode (im_q),
    .irq_en   (al_en_q),
    .flags    (flags),
    .irq      (irq)
  );

  // control register: mode bit and per-alarm interrupt gates
  always_ff @(posedge clk) begin
    if (rst) begin
      im_q    <= 1'b0;
      al_en_q <= '0;
    end else if (wr_en && (addr == CTRL_ADDR)) begin
      im_q    <= wdata[0];
      al_en_q <= wdata[N_ALARMS:1];
    end
  end

  always_comb begin
    rd_next = '0;
    if (rd_en) begin
      if (sel_alarm) begin
        if (int'(unit_sel) < N_ALARMS) rd_next = rd_vals[unit_sel];
      end else if (addr == CTRL_ADDR) begin
        rd_next = {{(DATA_W-N_ALARMS-1){1'b0}}, al_en_q, im_q};
      end else if (addr == STAT_ADDR) begin
        rd_next = {{(DATA_W-N_ALARMS){1'b0}}, flags};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_next;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk #(
  parameter int N_ALARMS = 2,
  parameter int ADDR_W   = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                tick,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [ADDR_W-1:0]   stat_addr,
  input logic [N_ALARMS-1:0] match,
  input logic [N_ALARMS-1:0] flags,
  input logic                rep_mode,
  input logic [N_ALARMS-1:0] irq_en,
  input logic                irq
);
  logic stat_rd;
  assign stat_rd = rd_en && (addr == stat_addr);

  // R1: reset leaves the interrupt and flags low
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!irq && (flags == '0)));

  // R5: no flag rises without a tick
  assert_no_flag_without_tick_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ((flags & ~$past(flags)) == '0));

  // R7: a status read with no tick leaves both flags clear
  assert_read_clears_R7: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !tick) |=> (flags == '0));

  // R8: in single-event mode a gated, set flag keeps the interrupt high
  assert_single_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (!rep_mode && !stat_rd && ((flags & irq_en) != '0)) |=> irq);

  // R9: a gated hit in repeat mode raises the interrupt
  assert_repeat_fires_R9: assert property (@(posedge clk) disable iff (rst)
    (rep_mode && tick && ((match & irq_en) != '0)) |=> irq);

  // R10: simultaneous hits set every flag
  assert_dual_hit_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && (&match)) |=> (&flags));

  // R11: with all gates closed the interrupt stays low
  assert_gated_off_R11: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq);
endmodule

bind cal_alarm_match cal_alarm_chk #(
  .N_ALARMS (N_ALARMS),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .rd_en     (rd_en),
  .addr      (addr),
  .stat_addr (STAT_ADDR),
  .match     (match_vec),
  .flags     (flags),
  .rep_mode  (im_q),
  .irq_en    (al_en_q),
  .irq       (irq)
);

// File: tb/tb_cal_alarm_match.sv
`timescale 1ns/1ps
module tb_cal_alarm_match;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [6:0] cur_sec = '0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [5:0] cur_date = 6'h01;
  logic [4:0] cur_month = 5'h01;
  logic [2:0] cur_wday = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  cal_alarm_match dut (
    .clk(clk), .rst(rst), .tick(tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .cur_month(cur_month), .cur_wday(cur_wday),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [7:0] m_al [2][6];
  logic       m_im;
  logic [1:0] m_en, m_flag, m_pulse;
  logic       m_irq;
  logic [7:0] m_rdata;

  function automatic logic [6:0] fmask(input int f);
    case (f)
      0, 1:    return 7'h7F;
      2, 3:    return 7'h3F;
      4:       return 7'h1F;
      default: return 7'h07;
    endcase
  endfunction

  function automatic logic [6:0] tfield(input int f);
    case (f)
      0:       return cur_sec;
      1:       return cur_min;
      2:       return {1'b0, cur_hour};
      3:       return {1'b0, cur_date};
      4:       return {2'b0, cur_month};
      default: return {4'b0, cur_wday};
    endcase
  endfunction

  function automatic logic hits(input int a);
    logic any = 1'b0;
    logic ok  = 1'b1;
    for (int f = 0; f < 6; f++) begin
      if (m_al[a][f][7]) begin
        any = 1'b1;
        if ((m_al[a][f][6:0] & fmask(f)) != (tfield(f) & fmask(f))) ok = 1'b0;
      end
    end
    return any && ok;
  endfunction

  always @(posedge clk) begin : model
    logic [1:0] mt, fn, pn, sl;
    logic       clr;
    logic [7:0] rv;
    if (rst) begin
      for (int a = 0; a < 2; a++) for (int f = 0; f < 6; f++) m_al[a][f] = '0;
      m_im = 0; m_en = 0; m_flag = 0; m_pulse = 0; m_irq = 0; m_rdata = 0;
    end else begin
      for (int a = 0; a < 2; a++) mt[a] = tick && hits(a);
      clr = rd_en && (addr == 5'd17);
      fn  = mt | (clr ? 2'b00 : m_flag);
      pn  = tick ? mt : m_pulse;
      sl  = m_im ? pn : fn;
      rv  = '0;
      if (rd_en) begin
        if (addr < 5'd16) begin
          if (addr[2:0] < 3'd6) rv = m_al[addr[3]][addr[2:0]];
        end else if (addr == 5'd16) rv = {5'b0, m_en, m_im};
        else if (addr == 5'd17) rv = {6'b0, m_flag};
      end
      m_rdata = rv;
      m_irq   = |(sl & m_en);
      m_flag  = fn;
      m_pulse = pn;
      if (wr_en) begin
        if (addr < 5'd16) begin
          if (addr[2:0] < 3'd6) m_al[addr[3]][addr[2:0]] = wdata;
        end else if (addr == 5'd16) begin
          m_im = wdata[0];
          m_en = wdata[2:1];
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check({cur_req, " irq vs model"}, irq, m_irq);
      check({cur_req, " rdata vs model"}, rdata, m_rdata);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    rd_en = 1; addr = a;
    @(negedge clk);
    d = rdata;
    rd_en = 0;
  endtask

  task automatic do_tick();
    tick = 1;
    @(negedge clk);
    tick = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 irq in reset", irq, 0);
    check("R1 rdata in reset", rdata, 0);
    rst = 0;
    @(negedge clk);
    rd(5'd17, v); check("R1 status after reset", v, 0);
    rd(5'd0, v);  check("R1 alarm field after reset", v, 0);
    rd(5'd16, v); check("R1 control after reset", v, 0);

    // R2: register map and readback
    cur_req = "R2";
    wr(5'd0, 8'h95);
    rd(5'd0, v);  check("R2 alarm0 sec readback", v, 8'h95);
    wr(5'd9, 8'hB0);
    rd(5'd9, v);  check("R2 alarm1 min readback", v, 8'hB0);
    rd(5'd7, v);  check("R2 unmapped read", v, 0);
    wr(5'd16, 8'hFF);
    rd(5'd16, v); check("R2 control readback", v, 8'h07);
    wr(5'd16, 8'h02);
    idle(1);      check("R2 rdata zero without read", rdata, 0);

    // R3 / R8: single-event alarm on seconds
    cur_req = "R3";
    cur_sec = 7'h15; cur_min = 7'h42; cur_hour = 6'h07;
    do_tick();
    check("R3 irq after sec hit", irq, 1);
    cur_req = "R8";
    idle(3);
    check("R8 irq held in single mode", irq, 1);
    rd(5'd17, v); check("R3 status flag", v, 8'h01);
    cur_req = "R7";
    check("R7 irq low after status read", irq, 0);
    rd(5'd17, v); check("R7 status cleared", v, 0);

    // R3: two enabled fields must both agree
    cur_req = "R3";
    wr(5'd2, 8'h87);
    cur_hour = 6'h08;
    do_tick();
    check("R3 hour mismatch blocks hit", irq, 0);
    cur_hour = 6'h07;
    do_tick();
    check("R3 sec and hour hit", irq, 1);
    rd(5'd17, v);
    wr(5'd2, 8'h07);

    // R4: disabled fields ignored
    cur_req = "R4";
    cur_min = 7'h11; cur_hour = 6'h23; cur_wday = 3'd6;
    do_tick();
    check("R4 disabled fields ignored", irq, 1);
    rd(5'd17, v); check("R4 status", v, 8'h01);

    // R5: matching time without a tick does nothing
    cur_req = "R5";
    idle(5);
    check("R5 irq without tick", irq, 0);
    rd(5'd17, v); check("R5 status without tick", v, 0);

    // R3: mismatching value
    cur_req = "R3";
    cur_sec = 7'h16;
    do_tick();
    check("R3 mismatch no irq", irq, 0);
    rd(5'd17, v); check("R3 mismatch no flag", v, 0);

    // R6: no enabled fields never fires
    cur_req = "R6";
    wr(5'd0, 8'h15);
    wr(5'd9, 8'h30);
    cur_sec = 7'h15; cur_min = 7'h30;
    do_tick();
    check("R6 irq with empty alarms", irq, 0);
    rd(5'd17, v); check("R6 status with empty alarms", v, 0);

    // R11: ungated alarm sets flag only
    cur_req = "R11";
    wr(5'd9, 8'hB0);
    cur_sec = 7'h00;
    do_tick();
    check("R11 ungated alarm1 no irq", irq, 0);
    rd(5'd17, v); check("R11 ungated flag set", v, 8'h02);

    // R10: both alarms on the same tick
    cur_req = "R10";
    wr(5'd0, 8'h95);
    wr(5'd16, 8'h06);
    cur_sec = 7'h15; cur_min = 7'h30;
    do_tick();
    check("R10 irq on dual hit", irq, 1);
    rd(5'd17, v); check("R10 both flags", v, 8'h03);

    // R9: repeat mode pulse lasts one tick period
    cur_req = "R9";
    wr(5'd16, 8'h03);
    cur_min = 7'h00;
    do_tick();
    check("R9 irq after repeat hit", irq, 1);
    idle(4);
    check("R9 irq held through tick period", irq, 1);
    cur_sec = 7'h16;
    do_tick();
    check("R9 irq drops on next tick", irq, 0);
    rd(5'd17, v); check("R9 flag latched in repeat", v, 8'h01);

    // R7: hit in the same cycle as a status read survives
    cur_req = "R7";
    cur_sec = 7'h15;
    tick = 1; rd_en = 1; addr = 5'd17;
    @(negedge clk);
    check("R7 read returns pre-hit flags", rdata, 0);
    tick = 0; rd_en = 0;
    rd(5'd17, v); check("R7 hit wins over clear", v, 8'h01);

    idle(2);
    finish_run();
  end
endmodule